// File: doc/BRIEF.md
# SMBus Host Block-Transfer Controller

This block is the register-facing core of an SMBus host. Software uses a small byte-wide register port to program a target address, a command byte and a byte count. It fills or drains a 32-entry block buffer through a single data window and sets a start bit. A sequencer then walks through the whole block write or block read. It does this by issuing one byte-level operation at a time to an external bus engine. The operations are start condition, send byte, receive byte and stop condition. Each operation is answered by one response carrying a received byte or a not-acknowledge flag.

The engine request channel is valid/ready. Once the controller raises `eng_cmd_valid`, the op, byte and ack fields stay frozen until a cycle in which `eng_cmd_ready` is high. At most one request is outstanding. The engine answers with a one-cycle `eng_rsp_valid` pulse, which the controller always accepts because it waits for it. Completion, device error and failure are reported in a write-one-to-clear status register and on a level interrupt.

Top module: `smb_host_ctrl`

## Requirements
- R1: After reset, status (offset 0x0), control (0x2), command (0x3), target address (0x4), count (0x5) and buffer mode (0xD) all read 0x00.
- R2: Status flags are cleared by writing ones. Writing back a value just read from status clears every flag it showed, and writes cannot change the busy bit (bit 0).
- R3: The data window at 0x7 reads or writes the buffer entry at a hidden index. When buffer mode bit 1 (offset 0xD) is set, every access advances the index. When that bit is clear, the index does not move. Any read of control (0x2) returns the index to entry 0.
- R4: A control write with bit 6 set, bits 4:2 equal to 5 and no transfer running starts a transfer, and busy (status bit 0) reads 1 from the next cycle. Bit 6 always reads back 0. A start with any other protocol value issues no bus operation and leaves busy at 0.
- R5: A block write issues start, the address byte with bit 0 cleared, the command, the count from 0x5, that many buffer bytes from entry 0 upward, and stop.
- R6: A block read issues start, the address byte with bit 0 cleared, the command, a second start, the address byte with bit 0 set, and a receive for the count byte, which is stored at 0x5. It then receives that many bytes into the buffer from entry 0, acknowledging every received byte except the last data byte, and ends with stop.
- R7: On a successful end, busy falls and status bit 1 (complete) is set. Bit 7 (byte done) is set once any data byte has moved.
- R8: A not-acknowledge on any sent byte sets status bit 2 (device error), sends stop next, and no further byte is sent.
- R9: A received count of 0 or above 32 sets status bit 4 (failed), and stop follows with no data receive.
- R10: Control bit 1 (kill) set while busy ends the transfer after the pending response with a stop, sets failed, and clears busy.
- R11: `irq` is high exactly when control bit 0 is set and any of status bits 1, 2, 3 or 4 is set.
- R12: Engine op codes are start=0, send=1, receive=2, stop=3, and `eng_cmd_ack`=1 means acknowledge. A request holds its fields while it waits for ready, and a new request is raised only after the previous one has been answered.
- R13: Status bit 6 (in use) reads 0 on the first status read and is set by that read. Later reads return 1 until a one is written to bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on reads of 0x0, 0x2, 0x7) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |
| eng_cmd_valid | output | 1 | Byte-engine request valid |
| eng_cmd_ready | input | 1 | Byte-engine request ready |
| eng_cmd_op | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 stop |
| eng_cmd_byte | output | 8 | Byte to send |
| eng_cmd_ack | output | 1 | For receive: 1 acknowledge, 0 not-acknowledge |
| eng_rsp_valid | input | 1 | One-cycle response pulse |
| eng_rsp_byte | input | 8 | Received byte |
| eng_rsp_nack | input | 1 | Device did not acknowledge the sent byte |

## Verification
On every cycle, the embedded assertions hold the request fields stable under back-pressure. They also check that busy follows an accepted start, that every fall of busy leaves a result flag behind, and that a not-acknowledge or an out-of-range count is followed directly by a stop request. Only the bench scenarios can show the full bus op order for block write and block read, the ack pattern on received bytes, and the data coming back through the stepping window. The same applies to index rewind on control reads, the in-use semaphore, the kill abort during a stalled byte, and the interrupt gating.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [3:0] OFS_STS  = 4'h0;
  localparam logic [3:0] OFS_CTL  = 4'h2;
  localparam logic [3:0] OFS_CMD  = 4'h3;
  localparam logic [3:0] OFS_TADR = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h5;
  localparam logic [3:0] OFS_AUX1 = 4'h6;
  localparam logic [3:0] OFS_WIN  = 4'h7;
  localparam logic [3:0] OFS_MODE = 4'hD;

  localparam logic [2:0] PROTO_BLOCK = 3'd5;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_DEV  = 2'd1,
    RES_FAIL = 2'd2
  } xfer_res_e;

  typedef enum logic [3:0] {
    PH_START, PH_ADDRW, PH_CMD, PH_CNTW, PH_DATW,
    PH_RSTART, PH_ADDRR, PH_CNTR, PH_DATR, PH_STOP
  } phase_e;
endpackage

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rewind,
  input  logic          step_en,
  output logic [DW-1:0] host_rdata,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] seq_wdata,
  output logic [DW-1:0] seq_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;

  assign host_rdata = mem[ptr];
  assign seq_rdata  = mem[seq_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (host_rewind) begin
      ptr <= '0;
    end else if ((host_rd || host_wr) && step_en) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (seq_we) begin
      mem[seq_addr] <= seq_wdata;
    end else if (host_wr) begin
      mem[ptr] <= host_wdata;
    end
  end

  // R3: a control read always lands the index on entry 0
  assert_rewind_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rewind |=> (ptr == '0));

  // R3: with stepping off, a window access leaves the index where it was
  assert_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !host_rewind) |=> $stable(ptr));
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          kill,
  input  logic          rd_dir,
  input  logic [6:0]    dev_addr,
  input  logic [7:0]    cmd_in,
  input  logic [7:0]    wr_count,
  input  logic [7:0]    buf_rdata,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  output logic          cnt_we,
  output logic [7:0]    cnt_val,
  output logic          byte_evt,
  output logic          done,
  output xfer_res_e     result,
  output logic          busy,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_ack,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_byte,
  input  logic          rsp_nack
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} st_e;

  st_e       st;
  phase_e    phase, nph;
  xfer_res_e res, nres;
  logic       rd_q, abort_q;
  logic [6:0] adr_q;
  logic [7:0] cmd_q, cnt_q, k;
  logic [7:0] k_inc;
  logic       is_send, take, fin, bad_cnt;

  assign k_inc     = 8'(k + 8'd1);
  assign is_send   = phase inside {PH_ADDRW, PH_CMD, PH_CNTW, PH_DATW, PH_ADDRR};
  assign take      = (st == S_RSP) && rsp_valid;
  assign bad_cnt   = (rsp_byte == 8'd0) || ({1'b0, rsp_byte} > 9'(DEPTH));
  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_REQ);
  assign buf_addr  = k[AW-1:0];
  assign buf_wdata = rsp_byte;
  assign cnt_val   = rsp_byte;
  assign result    = res;
  assign done      = fin;

  always_comb begin
    cmd_op   = OP_SEND;
    cmd_byte = 8'h00;
    cmd_ack  = 1'b1;
    unique case (phase)
      PH_START, PH_RSTART: cmd_op = OP_START;
      PH_STOP:             cmd_op = OP_STOP;
      PH_ADDRW:            cmd_byte = {adr_q, 1'b0};
      PH_ADDRR:            cmd_byte = {adr_q, 1'b1};
      PH_CMD:              cmd_byte = cmd_q;
      PH_CNTW:             cmd_byte = cnt_q;
      PH_DATW:             cmd_byte = buf_rdata;
      PH_CNTR:             cmd_op = OP_RECV;
      PH_DATR: begin
        cmd_op  = OP_RECV;
        cmd_ack = (k_inc != cnt_q);
      end
      default: cmd_op = OP_SEND;
    endcase
  end

  always_comb begin
    nph      = phase;
    nres     = res;
    buf_we   = 1'b0;
    cnt_we   = 1'b0;
    byte_evt = 1'b0;
    fin      = 1'b0;
    if (take) begin
      if (phase == PH_STOP) begin
        fin = 1'b1;
      end else if (abort_q || kill) begin
        nres = RES_FAIL;
        nph  = PH_STOP;
      end else if (is_send && rsp_nack) begin
        nres = RES_DEV;
        nph  = PH_STOP;
      end else begin
        unique case (phase)
          PH_START:  nph = PH_ADDRW;
          PH_ADDRW:  nph = PH_CMD;
          PH_CMD:    nph = rd_q ? PH_RSTART : PH_CNTW;
          PH_CNTW:   nph = (cnt_q == 8'd0) ? PH_STOP : PH_DATW;
          PH_DATW: begin
            byte_evt = 1'b1;
            nph      = (k_inc == cnt_q) ? PH_STOP : PH_DATW;
          end
          PH_RSTART: nph = PH_ADDRR;
          PH_ADDRR:  nph = PH_CNTR;
          PH_CNTR: begin
            cnt_we = 1'b1;
            if (bad_cnt) begin
              nres = RES_FAIL;
              nph  = PH_STOP;
            end else begin
              nph = PH_DATR;
            end
          end
          PH_DATR: begin
            buf_we   = 1'b1;
            byte_evt = 1'b1;
            nph      = (k_inc == cnt_q) ? PH_STOP : PH_DATR;
          end
          default: nph = PH_STOP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      phase   <= PH_START;
      res     <= RES_OK;
      rd_q    <= 1'b0;
      abort_q <= 1'b0;
      adr_q   <= '0;
      cmd_q   <= '0;
      cnt_q   <= '0;
      k       <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (go) begin
          st      <= S_REQ;
          phase   <= PH_START;
          res     <= RES_OK;
          abort_q <= 1'b0;
          rd_q    <= rd_dir;
          adr_q   <= dev_addr;
          cmd_q   <= cmd_in;
          cnt_q   <= wr_count;
          k       <= '0;
        end
        S_REQ: if (cmd_ready) st <= S_RSP;
        S_RSP: if (rsp_valid) begin
          if (fin) begin
            st <= S_IDLE;
          end else begin
            st    <= S_REQ;
            phase <= nph;
            res   <= nres;
            if (byte_evt) k <= k_inc;
            if (cnt_we) begin
              cnt_q <= rsp_byte;
              k     <= '0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (busy && kill) abort_q <= 1'b1;
    end
  end

  // R12: a request waiting for ready keeps all of its fields
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_ack)));

  // R8: a refused byte is followed directly by a stop request
  assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_send && rsp_nack) |=> (cmd_valid && cmd_op == OP_STOP));

  // R9: an out-of-range count is followed directly by a stop request
  assert_badcnt_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && phase == PH_CNTR && bad_cnt) |=> (cmd_valid && cmd_op == OP_STOP));
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       win_rd,
  output logic       win_wr,
  output logic       win_rewind,
  output logic       win_step,
  input  logic [7:0] win_rdata,
  output logic       go,
  output logic       kill,
  output logic       rd_dir,
  output logic [6:0] dev_addr,
  output logic [7:0] cmd_byte,
  output logic [7:0] wr_count,
  input  logic       seq_busy,
  input  logic       seq_done,
  input  xfer_res_e  seq_result,
  input  logic       byte_evt,
  input  logic       cnt_we,
  input  logic [7:0] cnt_val
);
  logic       c_ien, c_kill, c_last, c_pec;
  logic [2:0] c_proto;
  logic [7:0] cmd_q, tadr_q, cnt_q, aux1_q;
  logic [1:0] mode_q;
  logic       f_bdone, f_inuse, f_fail, f_dev, f_intr;
  logic       f_alert, f_buserr;
  logic       wr_sts, wr_ctl, rd_sts;

  assign f_alert  = 1'b0;
  assign f_buserr = 1'b0;
  assign wr_sts = reg_wr && (reg_addr == OFS_STS);
  assign wr_ctl = reg_wr && (reg_addr == OFS_CTL);
  assign rd_sts = reg_rd && (reg_addr == OFS_STS);

  assign win_rd     = reg_rd && (reg_addr == OFS_WIN);
  assign win_wr     = reg_wr && (reg_addr == OFS_WIN) && !seq_busy;
  assign win_rewind = reg_rd && (reg_addr == OFS_CTL);
  assign win_step   = mode_q[1];

  assign go       = wr_ctl && reg_wdata[6] && (reg_wdata[4:2] == PROTO_BLOCK) && !seq_busy;
  assign kill     = c_kill;
  assign rd_dir   = tadr_q[0];
  assign dev_addr = tadr_q[7:1];
  assign cmd_byte = cmd_q;
  assign wr_count = cnt_q;

  assign irq = c_ien && (f_intr || f_dev || f_buserr || f_fail);

  always_comb begin
    unique case (reg_addr)
      OFS_STS:  reg_rdata = {f_bdone, f_inuse, f_alert, f_fail, f_buserr, f_dev, f_intr, seq_busy};
      OFS_CTL:  reg_rdata = {c_pec, 1'b0, c_last, c_proto, c_kill, c_ien};
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_TADR: reg_rdata = tadr_q;
      OFS_CNT:  reg_rdata = cnt_q;
      OFS_AUX1: reg_rdata = aux1_q;
      OFS_WIN:  reg_rdata = win_rdata;
      OFS_MODE: reg_rdata = {6'd0, mode_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_ien <= 1'b0; c_kill <= 1'b0; c_last <= 1'b0; c_pec <= 1'b0;
      c_proto <= '0;
      cmd_q <= '0; tadr_q <= '0; cnt_q <= '0; aux1_q <= '0; mode_q <= '0;
    end else begin
      if (wr_ctl) begin
        c_ien   <= reg_wdata[0];
        c_kill  <= reg_wdata[1];
        c_proto <= reg_wdata[4:2];
        c_last  <= reg_wdata[5];
        c_pec   <= reg_wdata[7];
      end
      if (reg_wr && reg_addr == OFS_CMD)  cmd_q  <= reg_wdata;
      if (reg_wr && reg_addr == OFS_TADR) tadr_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_AUX1) aux1_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_MODE) mode_q <= reg_wdata[1:0];
      if (cnt_we) cnt_q <= cnt_val;
      else if (reg_wr && reg_addr == OFS_CNT) cnt_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_bdone <= 1'b0; f_inuse <= 1'b0; f_fail <= 1'b0; f_dev <= 1'b0; f_intr <= 1'b0;
    end else begin
      if (wr_sts) begin
        if (reg_wdata[7]) f_bdone <= 1'b0;
        if (reg_wdata[6]) f_inuse <= 1'b0;
        if (reg_wdata[4]) f_fail  <= 1'b0;
        if (reg_wdata[2]) f_dev   <= 1'b0;
        if (reg_wdata[1]) f_intr  <= 1'b0;
      end
      if (rd_sts && !f_inuse) f_inuse <= 1'b1;
      if (byte_evt) f_bdone <= 1'b1;
      if (seq_done) begin
        unique case (seq_result)
          RES_OK:   f_intr <= 1'b1;
          RES_DEV:  f_dev  <= 1'b1;
          default:  f_fail <= 1'b1;
        endcase
      end
    end
  end

  // R4: an accepted start shows as busy on the next cycle
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> seq_busy);

  // R7: whenever busy drops, a result flag is left in status
  assert_end_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> (f_intr || f_dev || f_fail));
endmodule

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
  import smb_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int BAW      = $clog2(BUF_DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       eng_cmd_valid,
  input  logic       eng_cmd_ready,
  output logic [1:0] eng_cmd_op,
  output logic [7:0] eng_cmd_byte,
  output logic       eng_cmd_ack,
  input  logic       eng_rsp_valid,
  input  logic [7:0] eng_rsp_byte,
  input  logic       eng_rsp_nack
);
  logic            win_rd, win_wr, win_rewind, win_step;
  logic [7:0]      win_rdata;
  logic            go, kill, rd_dir;
  logic [6:0]      dev_addr;
  logic [7:0]      cmd_b, wr_count;
  logic            seq_busy, seq_done, byte_evt, cnt_we, buf_we;
  logic [7:0]      cnt_val, buf_wdata, buf_rdata;
  logic [BAW-1:0]  buf_addr;
  xfer_res_e       seq_result;

  smb_regfile u_regs (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .win_rd, .win_wr, .win_rewind, .win_step, .win_rdata,
    .go, .kill, .rd_dir, .dev_addr, .cmd_byte(cmd_b), .wr_count,
    .seq_busy, .seq_done, .seq_result, .byte_evt, .cnt_we, .cnt_val
  );

  smb_blkbuf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk, .rst_n,
    .host_rd(win_rd), .host_wr(win_wr), .host_wdata(reg_wdata),
    .host_rewind(win_rewind), .step_en(win_step), .host_rdata(win_rdata),
    .seq_we(buf_we), .seq_addr(buf_addr), .seq_wdata(buf_wdata), .seq_rdata(buf_rdata)
  );

  smb_seq #(.DEPTH(BUF_DEPTH)) u_seq (
    .clk, .rst_n, .go, .kill, .rd_dir, .dev_addr, .cmd_in(cmd_b), .wr_count,
    .buf_rdata, .buf_addr, .buf_we, .buf_wdata, .cnt_we, .cnt_val, .byte_evt,
    .done(seq_done), .result(seq_result), .busy(seq_busy),
    .cmd_valid(eng_cmd_valid), .cmd_ready(eng_cmd_ready), .cmd_op(eng_cmd_op),
    .cmd_byte(eng_cmd_byte), .cmd_ack(eng_cmd_ack),
    .rsp_valid(eng_rsp_valid), .rsp_byte(eng_rsp_byte), .rsp_nack(eng_rsp_nack)
  );
endmodule

// File: tb/sim_smb_host_ctrl.sv
module sim_smb_host_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       eng_cmd_valid, eng_cmd_ack;
  logic       eng_cmd_ready = 1'b0;
  logic [1:0] eng_cmd_op;
  logic [7:0] eng_cmd_byte;
  logic       eng_rsp_valid = 1'b0, eng_rsp_nack = 1'b0;
  logic [7:0] eng_rsp_byte = '0;

  int checks = 0, failures = 0;
  logic [9:0] exp_q[$];
  logic [7:0] rx_q[$];
  logic       hold = 1'b0, nack_en = 1'b0;
  logic [7:0] nack_byte = '0;

  always #2.5 clk = ~clk;

  smb_host_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b);
    exp_q.push_back({op, b});
  endtask

  // byte engine model and scoreboard monitor
  initial begin : engine
    logic       pend = 1'b0;
    logic [1:0] pop_op = 2'd0;
    logic [7:0] pbyte = '0;
    logic       pnack = 1'b0;
    int         wcnt = 0;
    forever begin
      @(negedge clk);
      eng_rsp_valid = 1'b0;
      if (pend) begin
        eng_cmd_ready = 1'b0;
        if (!(hold && pop_op == 2'd1)) begin
          if (wcnt == 0) begin
            eng_rsp_valid = 1'b1;
            eng_rsp_byte  = pbyte;
            eng_rsp_nack  = pnack;
            pend = 1'b0;
          end else wcnt--;
        end
      end else begin
        eng_cmd_ready = ~eng_cmd_ready;
        if (eng_cmd_valid && eng_cmd_ready) begin
          logic [9:0] got;
          got = {eng_cmd_op, (eng_cmd_op == 2'd2) ? {7'd0, eng_cmd_ack} : eng_cmd_byte};
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R12 unexpected bus op act=%0h exp=none", got);
          end else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            if (got !== e) begin
              failures++;
              $display("FAIL R12 bus op order act=%0h exp=%0h", got, e);
            end
          end
          pend = 1'b1; pop_op = eng_cmd_op; wcnt = 1; pnack = 1'b0; pbyte = 8'h00;
          if (eng_cmd_op == 2'd1) pnack = nack_en && (eng_cmd_byte == nack_byte);
          if (eng_cmd_op == 2'd2 && rx_q.size() > 0) pbyte = rx_q.pop_front();
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle(output logic [7:0] s);
    for (int i = 0; i < 3000; i++) begin
      rd(4'h0, s);
      if (!s[0]) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] s, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(4'h0, v); chk("R1 status", v, 8'h00);
    rd(4'h2, v); chk("R1 control", v, 8'h00);
    rd(4'h3, v); chk("R1 command", v, 8'h00);
    rd(4'h4, v); chk("R1 target", v, 8'h00);
    rd(4'h5, v); chk("R1 count", v, 8'h00);
    rd(4'hD, v); chk("R1 mode", v, 8'h00);

    // R13 in-use semaphore
    rd(4'h0, v); chk("R13 second read", v, 8'h40);
    wr(4'h0, 8'h40);
    rd(4'h0, v); chk("R13 after clear", v, 8'h00);
    rd(4'h0, v); chk("R13 set again", v, 8'h40);
    wr(4'h0, 8'h40);

    // R3 data window stepping and rewind
    wr(4'hD, 8'h02);
    rd(4'h2, v);
    wr(4'h7, 8'hA1); wr(4'h7, 8'hA2); wr(4'h7, 8'hA3);
    rd(4'h2, v);
    rd(4'h7, v); chk("R3 entry0", v, 8'hA1);
    rd(4'h7, v); chk("R3 entry1", v, 8'hA2);
    rd(4'h2, v);
    rd(4'h7, v); chk("R3 rewind", v, 8'hA1);
    rd(4'h2, v);
    wr(4'hD, 8'h00);
    wr(4'h7, 8'h55); wr(4'h7, 8'h66);
    rd(4'h7, v); chk("R3 no step write", v, 8'h66);
    rd(4'h7, v); chk("R3 no step read", v, 8'h66);
    wr(4'hD, 8'h02);
    rd(4'h2, v);
    rd(4'h7, v); rd(4'h7, v); chk("R3 entry1 kept", v, 8'hA2);

    // R4 start with wrong protocol is ignored
    wr(4'h2, 8'h40);
    repeat (10) @(negedge clk);
    rd(4'h0, v); chk("R4 no busy", v & 8'h01, 8'h00);
    chk("R4 no bus op", exp_q.size(), 0);

    // R5 block write
    wr(4'h4, 8'h58); wr(4'h3, 8'h10); wr(4'h5, 8'h03);
    rd(4'h2, v);
    wr(4'h7, 8'h11); wr(4'h7, 8'h22); wr(4'h7, 8'h33);
    push(2'd0, 8'h00); push(2'd1, 8'h58); push(2'd1, 8'h10); push(2'd1, 8'h03);
    push(2'd1, 8'h11); push(2'd1, 8'h22); push(2'd1, 8'h33); push(2'd3, 8'h00);
    wr(4'h2, 8'h54);
    rd(4'h0, v); chk("R4 busy after start", v & 8'h01, 8'h01);
    rd(4'h2, v); chk("R4 start reads 0", v, 8'h14);
    wait_idle(s);
    chk("R5 all ops seen", exp_q.size(), 0);
    chk("R7 write done flags", s & 8'h9F, 8'h82);
    chk("R11 irq masked", irq, 1'b0);
    wr(4'h2, 8'h15);
    chk("R11 irq enabled", irq, 1'b1);
    wr(4'h0, s);
    chk("R11 irq after clear", irq, 1'b0);
    rd(4'h0, v); chk("R2 writeback clears", v & 8'hBF, 8'h00);
    wr(4'h0, 8'h40);

    // R6 block read
    wr(4'h4, 8'h59); wr(4'h3, 8'h20);
    rx_q.push_back(8'h04);
    rx_q.push_back(8'hD0); rx_q.push_back(8'hD1); rx_q.push_back(8'hD2); rx_q.push_back(8'hD3);
    push(2'd0, 8'h00); push(2'd1, 8'h58); push(2'd1, 8'h20); push(2'd0, 8'h00);
    push(2'd1, 8'h59); push(2'd2, 8'h01); push(2'd2, 8'h01); push(2'd2, 8'h01);
    push(2'd2, 8'h01); push(2'd2, 8'h00); push(2'd3, 8'h00);
    wr(4'h2, 8'h55);
    wait_idle(s);
    chk("R6 all ops seen", exp_q.size(), 0);
    chk("R7 read done flags", s & 8'h9F, 8'h82);
    chk("R11 irq on read done", irq, 1'b1);
    rd(4'h5, v); chk("R6 count stored", v, 8'h04);
    rd(4'h2, v);
    for (int i = 0; i < 4; i++) begin
      rd(4'h7, v); chk("R6 read data", v, 8'hD0 + 8'(i));
    end
    wr(4'h0, s);

    // R8 nack on command byte
    nack_en = 1'b1; nack_byte = 8'h10;
    wr(4'h4, 8'h58); wr(4'h3, 8'h10); wr(4'h5, 8'h02);
    push(2'd0, 8'h00); push(2'd1, 8'h58); push(2'd1, 8'h10); push(2'd3, 8'h00);
    wr(4'h2, 8'h54);
    wait_idle(s);
    chk("R8 ops stop after nack", exp_q.size(), 0);
    chk("R8 device error", s & 8'h9F, 8'h04);
    wr(4'h0, s);
    nack_en = 1'b0;

    // R9 bad counts: zero and 40
    for (int j = 0; j < 2; j++) begin
      wr(4'h4, 8'h59); wr(4'h3, 8'h20);
      rx_q.push_back(j == 0 ? 8'd0 : 8'd40);
      push(2'd0, 8'h00); push(2'd1, 8'h58); push(2'd1, 8'h20); push(2'd0, 8'h00);
      push(2'd1, 8'h59); push(2'd2, 8'h01); push(2'd3, 8'h00);
      wr(4'h2, 8'h54);
      wait_idle(s);
      chk("R9 no data receive", exp_q.size(), 0);
      chk("R9 failed flag", s & 8'h9F, 8'h10);
      wr(4'h0, s);
    end

    // R10 kill during a stalled address byte
    hold = 1'b1;
    wr(4'h4, 8'h58); wr(4'h3, 8'h10); wr(4'h5, 8'h01);
    push(2'd0, 8'h00); push(2'd1, 8'h58); push(2'd3, 8'h00);
    wr(4'h2, 8'h54);
    repeat (30) @(negedge clk);
    rd(4'h0, v); chk("R10 busy while stalled", v & 8'h01, 8'h01);
    wr(4'h2, 8'h16);
    hold = 1'b0;
    wait_idle(s);
    chk("R10 stop after kill", exp_q.size(), 0);
    chk("R10 failed not busy", s & 8'h9F, 8'h10);
    wr(4'h2, 8'h14);
    wr(4'h0, s);
    rd(4'h0, v); chk("R2 failed cleared", v & 8'hBF, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule